// File: doc/BRIEF.md
# System MMU Control and Fault Register Block

This block is the software-visible register file that sits beside a system MMU's translation datapath. A host writes and reads 32-bit words over a minimal register bus: address, write enable and write data in, read data out combinationally. From those registers the block drives a translation-on level, a hold level that stalls new translations, the page-table base and a configuration word toward the datapath. It also issues single-cycle invalidate strobes for the whole translation cache or for one 4 KB page.

The datapath reports translation faults as a bit vector of eight fault types, with one shared faulting address. The block records every reported type in an interrupt status register and raises its interrupt line while any status bit is set. It files the address into one of four fault-address registers picked by the type: page, write-side, read-side or bus error. A fault forces the unit into the held state. Software clears the recorded types with write-one-to-clear and then writes the run code to resume.

A hold request, whether from software or from a fault, drains for a fixed two cycles before the status register reports that the unit is held.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset, translation is off, hold is low, the interrupt line is low, and the control (0x000), status (0x008) and interrupt status (0x018) registers read 0.
- R2: Writing 0x5 to control (0x000) turns translation on and releases hold. Writing 0x0 turns it off. Control reads back 0x0, 0x5 or 0x7 for off, running and held. A write of any other value is ignored.
- R3: Writing 0x7 to control raises hold in the cycle after the write. Status bit 0 reads 0 in that cycle and the next, and reads 1 from the second cycle after the write edge onward.
- R4: A fault on any bit of the fault vector sets that bit of interrupt status in the next cycle. It also forces the held state: hold and translation-on are high, and the same drain delay as R3 applies.
- R5: Interrupt status bit positions are: 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write access. The fault address goes to 0x024 for bit 0, 0x028 for bits 2/6/7, 0x02C for bits 1/4/5 and 0x030 for bit 3.
- R6: When several fault types arrive in the same cycle, all of their bits are set. Each fault-address register keeps its first captured address while any status bit routed to it is still set, and captures again once all of them are clear.
- R7: Writing to interrupt clear (0x01C) clears each status bit written as 1 and leaves the others. A fault arriving in the same cycle as a clear of its bit leaves the bit set.
- R8: While any status bit is set, control writes of 0x5 or 0x0 are ignored and hold stays high. Once status is all clear, writing 0x5 drops hold and status bit 0 reads 0.
- R9: Writing a value with bit 0 set to the flush register (0x00C) pulses the flush-all output high for exactly one cycle after the write. A value with bit 0 clear produces no pulse.
- R10: Writing to flush-entry (0x010) with bit 0 set pulses flush-one for exactly one cycle after the write and presents write-data bits 31:12 as the page number. A write with bit 0 clear produces no pulse.
- R11: Config (0x004) and table base (0x014) are read/write and drive their outputs. Version (0x034) reads 0x3100_0000. Interrupt status and the fault-address registers ignore bus writes.
- R12: The interrupt line is high exactly while any interrupt status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write enable for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| flt_hit | input | 8 | Fault types reported this cycle, one bit per type |
| flt_va | input | 32 | Device address of the reported fault |
| xlat_on | output | 1 | Translation enabled (running or held) |
| xlat_hold | output | 1 | Stall new translations |
| cfg_word | output | 32 | Configuration register value |
| tbl_base | output | 32 | Page-table base address |
| flush_all | output | 1 | One-cycle invalidate-all strobe |
| flush_one | output | 1 | One-cycle invalidate-one-page strobe |
| flush_va | output | 20 | Page number for flush_one |
| irq | output | 1 | Fault interrupt |

## Verification
Register reads are combinational, so the bench checks read data in the same cycle it drives the address. Control levels, interrupt status, the interrupt line, fault addresses and the flush strobes change at the write or fault edge, so the bench checks them one cycle later. The held flag in status bit 0 appears two edges after the hold request. The bench walks through those cycles one at a time, reading the held flag after each edge. The scoreboard samples on the falling edge, after the driver has pushed that cycle's expectations, so every comparison lands on the cycle the requirement names.

// File: rtl/mmu_regs_pkg.sv
`timescale 1ns/1ps
package mmu_regs_pkg;

  localparam int DATA_W = 32;
  localparam int NFLT   = 8;
  localparam int NGRP   = 4;

  // register byte offsets (fixed: software decodes them)
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_CFG   = 8'h04;
  localparam logic [7:0] OFS_STAT  = 8'h08;
  localparam logic [7:0] OFS_FLALL = 8'h0C;
  localparam logic [7:0] OFS_FLONE = 8'h10;
  localparam logic [7:0] OFS_BASE  = 8'h14;
  localparam logic [7:0] OFS_ISR   = 8'h18;
  localparam logic [7:0] OFS_ICLR  = 8'h1C;
  localparam logic [7:0] OFS_APAGE = 8'h24;
  localparam logic [7:0] OFS_AWR   = 8'h28;
  localparam logic [7:0] OFS_ARD   = 8'h2C;
  localparam logic [7:0] OFS_ABUS  = 8'h30;
  localparam logic [7:0] OFS_VER   = 8'h34;

  // control codes
  localparam logic [DATA_W-1:0] CODE_OFF  = 32'h0;
  localparam logic [DATA_W-1:0] CODE_RUN  = 32'h5;
  localparam logic [DATA_W-1:0] CODE_HOLD = 32'h7;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_HOLD = 2'd2
  } mode_e;

  // fault-address register groups, index = register slot
  localparam int GRP_PAGE = 0;
  localparam int GRP_WR   = 1;
  localparam int GRP_RD   = 2;
  localparam int GRP_BUS  = 3;

  // which status bits route their address to a given group
  function automatic logic [NFLT-1:0] grp_mask(input int g);
    logic [NFLT-1:0] m;
    m = '0;
    case (g)
      GRP_PAGE: m[0] = 1'b1;
      GRP_WR:   begin m[2] = 1'b1; m[6] = 1'b1; m[7] = 1'b1; end
      GRP_RD:   begin m[1] = 1'b1; m[4] = 1'b1; m[5] = 1'b1; end
      default:  m[3] = 1'b1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mmu_ctl_fsm.sv
`timescale 1ns/1ps
module mmu_ctl_fsm
  import mmu_regs_pkg::*;
#(
  parameter int DRAIN_CYC = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_run,
  input  logic  wr_hold,
  input  logic  wr_off,
  input  logic  fault_in,
  input  logic  pend,
  output mode_e mode_o,
  output logic  blk_done
);

  localparam int CNT_W = $clog2(DRAIN_CYC + 1);

  mode_e            mode_q, mode_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;

  always_comb begin
    mode_n = mode_q;
    cnt_n  = cnt_q;
    done_n = done_q;
    if (fault_in || wr_hold) begin
      if (mode_q != MODE_HOLD) begin
        mode_n = MODE_HOLD;
        cnt_n  = '0;
        done_n = 1'b0;
      end else if (!done_q) begin
        if (cnt_q == CNT_W'(DRAIN_CYC - 1)) done_n = 1'b1;
        else                                cnt_n  = cnt_q + 1'b1;
      end
    end else if ((wr_run || wr_off) && !pend) begin
      mode_n = wr_run ? MODE_RUN : MODE_OFF;
      cnt_n  = '0;
      done_n = 1'b0;
    end else if (mode_q == MODE_HOLD && !done_q) begin
      if (cnt_q == CNT_W'(DRAIN_CYC - 1)) done_n = 1'b1;
      else                                cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign mode_o   = mode_q;
  assign blk_done = done_q;

endmodule

// File: rtl/mmu_fault_log.sv
`timescale 1ns/1ps
module mmu_fault_log
  import mmu_regs_pkg::*;
#(
  parameter int NF = NFLT,
  parameter int DW = DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NF-1:0]            flt_hit,
  input  logic [DW-1:0]            flt_va,
  input  logic                     clr_we,
  input  logic [NF-1:0]            clr_bits,
  output logic [NF-1:0]            status,
  output logic [NGRP-1:0][DW-1:0]  grp_addr
);

  logic [NF-1:0] st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (clr_we) st_n = st_n & ~clr_bits;
    st_n = st_n | flt_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end

  assign status = st_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [NF-1:0] MASK = NF'(grp_mask(g));
    logic          cap;
    logic [DW-1:0] a_q, a_n;

    always_comb begin
      cap = (|(flt_hit & MASK)) && !(|(st_q & MASK));
      a_n = cap ? flt_va : a_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) a_q <= '0;
      else        a_q <= a_n;
    end

    assign grp_addr[g] = a_q;
  end

endmodule

// File: rtl/mmu_flush_gen.sv
`timescale 1ns/1ps
module mmu_flush_gen #(
  parameter int VA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_all,
  input  logic            wr_one,
  input  logic            go_bit,
  input  logic [VA_W-1:0] page_in,
  output logic            flush_all,
  output logic            flush_one,
  output logic [VA_W-1:0] flush_va
);

  logic            all_q, all_n;
  logic            one_q, one_n;
  logic [VA_W-1:0] va_q, va_n;

  always_comb begin
    all_n = wr_all && go_bit;
    one_n = wr_one && go_bit;
    va_n  = one_n ? page_in : va_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_q <= 1'b0;
      one_q <= 1'b0;
      va_q  <= '0;
    end else begin
      all_q <= all_n;
      one_q <= one_n;
      va_q  <= va_n;
    end
  end

  assign flush_all = all_q;
  assign flush_one = one_q;
  assign flush_va  = va_q;

endmodule

// File: rtl/mmu_ctl_regs.sv
`timescale 1ns/1ps
module mmu_ctl_regs
  import mmu_regs_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              PAGE_SH   = 12,
  parameter int              DRAIN_CYC = 2,
  parameter logic [DATA_W-1:0] VERSION = 32'h3100_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [NFLT-1:0]           flt_hit,
  input  logic [DATA_W-1:0]         flt_va,
  output logic                      xlat_on,
  output logic                      xlat_hold,
  output logic [DATA_W-1:0]         cfg_word,
  output logic [DATA_W-1:0]         tbl_base,
  output logic                      flush_all,
  output logic                      flush_one,
  output logic [DATA_W-PAGE_SH-1:0] flush_va,
  output logic                      irq
);

  localparam int VA_W = DATA_W - PAGE_SH;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // write strobes
  logic wr_ctrl, wr_cfg, wr_base, wr_clr, wr_fla, wr_fl1;
  logic wr_run, wr_hold, wr_off;

  always_comb begin
    wr_ctrl = reg_wr && hit(reg_addr, OFS_CTRL);
    wr_cfg  = reg_wr && hit(reg_addr, OFS_CFG);
    wr_base = reg_wr && hit(reg_addr, OFS_BASE);
    wr_clr  = reg_wr && hit(reg_addr, OFS_ICLR);
    wr_fla  = reg_wr && hit(reg_addr, OFS_FLALL);
    wr_fl1  = reg_wr && hit(reg_addr, OFS_FLONE);
    wr_run  = wr_ctrl && (reg_wdata == CODE_RUN);
    wr_hold = wr_ctrl && (reg_wdata == CODE_HOLD);
    wr_off  = wr_ctrl && (reg_wdata == CODE_OFF);
  end

  // plain storage registers with explicit enables
  logic [DATA_W-1:0] cfg_q, cfg_n, base_q, base_n;

  always_comb begin
    cfg_n  = wr_cfg  ? reg_wdata : cfg_q;
    base_n = wr_base ? reg_wdata : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else begin
      cfg_q  <= cfg_n;
      base_q <= base_n;
    end
  end

  // fault log
  logic [NFLT-1:0]               isr;
  logic [NGRP-1:0][DATA_W-1:0]   faddr;

  mmu_fault_log #(.NF(NFLT), .DW(DATA_W)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt_hit  (flt_hit),
    .flt_va   (flt_va),
    .clr_we   (wr_clr),
    .clr_bits (reg_wdata[NFLT-1:0]),
    .status   (isr),
    .grp_addr (faddr)
  );

  // control state
  mode_e mode;
  logic  blk_done;

  mmu_ctl_fsm #(.DRAIN_CYC(DRAIN_CYC)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_run   (wr_run),
    .wr_hold  (wr_hold),
    .wr_off   (wr_off),
    .fault_in (|flt_hit),
    .pend     (|isr),
    .mode_o   (mode),
    .blk_done (blk_done)
  );

  // invalidate strobes
  mmu_flush_gen #(.VA_W(VA_W)) u_fl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_all    (wr_fla),
    .wr_one    (wr_fl1),
    .go_bit    (reg_wdata[0]),
    .page_in   (reg_wdata[DATA_W-1:PAGE_SH]),
    .flush_all (flush_all),
    .flush_one (flush_one),
    .flush_va  (flush_va)
  );

  // outputs
  assign xlat_on   = (mode != MODE_OFF);
  assign xlat_hold = (mode == MODE_HOLD);
  assign cfg_word  = cfg_q;
  assign tbl_base  = base_q;
  assign irq       = |isr;

  // read mux
  logic [DATA_W-1:0] ctrl_code;

  always_comb begin
    case (mode)
      MODE_RUN:  ctrl_code = CODE_RUN;
      MODE_HOLD: ctrl_code = CODE_HOLD;
      default:   ctrl_code = CODE_OFF;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    if      (hit(reg_addr, OFS_CTRL))  reg_rdata = ctrl_code;
    else if (hit(reg_addr, OFS_CFG))   reg_rdata = cfg_q;
    else if (hit(reg_addr, OFS_STAT))  reg_rdata = {{(DATA_W-1){1'b0}}, blk_done};
    else if (hit(reg_addr, OFS_BASE))  reg_rdata = base_q;
    else if (hit(reg_addr, OFS_ISR))   reg_rdata = DATA_W'(isr);
    else if (hit(reg_addr, OFS_APAGE)) reg_rdata = faddr[GRP_PAGE];
    else if (hit(reg_addr, OFS_AWR))   reg_rdata = faddr[GRP_WR];
    else if (hit(reg_addr, OFS_ARD))   reg_rdata = faddr[GRP_RD];
    else if (hit(reg_addr, OFS_ABUS))  reg_rdata = faddr[GRP_BUS];
    else if (hit(reg_addr, OFS_VER))   reg_rdata = VERSION;
  end

endmodule

// File: rtl/mmu_ctl_regs_chk.sv
`timescale 1ns/1ps
module mmu_ctl_regs_chk
  import mmu_regs_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NFLT-1:0] flt_hit,
  input logic            irq,
  input logic            xlat_on,
  input logic            xlat_hold,
  input logic            flush_all,
  input logic            flush_one,
  input logic            blk_done
);

  // R3
  hold_rise_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xlat_hold) |=> !blk_done);

  // R3
  done_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_done) |-> ($past(xlat_hold, 1) && $past(xlat_hold, 2)));

  // R4
  fault_forces_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flt_hit) |=> (xlat_hold && xlat_on));

  // R12
  fault_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flt_hit) |=> irq);

  // R8
  pending_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && xlat_hold) |=> xlat_hold);

  // R9
  flush_all_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !flush_all);

  // R10
  flush_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_one |=> !flush_one);

endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flt_hit   (flt_hit),
  .irq       (irq),
  .xlat_on   (xlat_on),
  .xlat_hold (xlat_hold),
  .flush_all (flush_all),
  .flush_one (flush_one),
  .blk_done  (blk_done)
);

// File: tb/mmu_ctl_regs_tb.sv
`timescale 1ns/1ps
module mmu_ctl_regs_tb;

  localparam logic [7:0] A_CTRL = 8'h00, A_CFG = 8'h04, A_STAT = 8'h08,
                         A_FLA  = 8'h0C, A_FL1 = 8'h10, A_BASE = 8'h14,
                         A_ISR  = 8'h18, A_CLR = 8'h1C, A_PG   = 8'h24,
                         A_WR   = 8'h28, A_RD  = 8'h2C, A_BE   = 8'h30,
                         A_VER  = 8'h34;

  localparam int S_RD = 0, S_ON = 1, S_HOLD = 2, S_IRQ = 3, S_FA = 4,
                 S_FO = 5, S_FVA = 6, S_CFG = 7, S_BASE = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  flt_hit;
  logic [31:0] flt_va;
  logic        xlat_on, xlat_hold, flush_all, flush_one, irq;
  logic [31:0] cfg_word, tbl_base;
  logic [19:0] flush_va;

  always #2.5 clk = ~clk;

  mmu_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_hit(flt_hit),
    .flt_va(flt_va), .xlat_on(xlat_on), .xlat_hold(xlat_hold),
    .cfg_word(cfg_word), .tbl_base(tbl_base), .flush_all(flush_all),
    .flush_one(flush_one), .flush_va(flush_va), .irq(irq)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;

  function automatic logic [31:0] observe(input int sel);
    case (sel)
      S_RD:    return reg_rdata;
      S_ON:    return {31'b0, xlat_on};
      S_HOLD:  return {31'b0, xlat_hold};
      S_IRQ:   return {31'b0, irq};
      S_FA:    return {31'b0, flush_all};
      S_FO:    return {31'b0, flush_one};
      S_FVA:   return {12'b0, flush_va};
      S_CFG:   return cfg_word;
      default: return tbl_base;
    endcase
  endfunction

  // monitor: compare every expectation due this cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it  = q.pop_front();
      got = observe(it.sel);
      n_chk++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: sel %0d got 0x%08h expected 0x%08h", it.tag, it.sel, got, it.exp);
      end
    end
  end

  task automatic expect_obs(input int sel, input logic [31:0] e, input string tag);
    item_t it;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic sync();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    expect_obs(S_RD, e, tag);
    sync();
  endtask

  task automatic fault(input logic [7:0] bits, input logic [31:0] va);
    flt_hit = bits; flt_va = va;
    tick();
    flt_hit = '0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    flt_hit = '0; flt_va = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    expect_obs(S_ON, 0, "R1 on");
    expect_obs(S_HOLD, 0, "R1 hold");
    expect_obs(S_IRQ, 0, "R1 irq");
    rd(A_CTRL, 0, "R1 ctrl");
    rd(A_STAT, 0, "R1 status");
    rd(A_ISR, 0, "R1 isr");
    rd(A_VER, 32'h3100_0000, "R11 version");

    // R11 plain registers and read-only ones
    wr(A_CFG, 32'h0000_0001);
    wr(A_BASE, 32'h8000_4000);
    expect_obs(S_CFG, 32'h1, "R11 cfg out");
    expect_obs(S_BASE, 32'h8000_4000, "R11 base out");
    rd(A_CFG, 32'h1, "R11 cfg read");
    rd(A_BASE, 32'h8000_4000, "R11 base read");
    wr(A_ISR, 32'hFF);
    rd(A_ISR, 0, "R11 isr read-only");
    wr(A_PG, 32'h1234);
    rd(A_PG, 0, "R11 fault addr read-only");

    // R2 run, illegal code ignored
    wr(A_CTRL, 32'h5);
    expect_obs(S_ON, 1, "R2 on");
    expect_obs(S_HOLD, 0, "R2 hold low");
    rd(A_CTRL, 32'h5, "R2 ctrl run");
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, 32'h5, "R2 illegal ignored");

    // R3 hold request and drain timing
    wr(A_CTRL, 32'h7);
    expect_obs(S_HOLD, 1, "R3 hold next cycle");
    rd(A_STAT, 0, "R3 status +1");
    tick();
    rd(A_STAT, 0, "R3 status +2 cycle");
    tick();
    rd(A_STAT, 1, "R3 status held");
    rd(A_CTRL, 32'h7, "R2 ctrl held code");
    wr(A_CTRL, 32'h5);
    expect_obs(S_HOLD, 0, "R8 release no pending");
    rd(A_STAT, 0, "R8 status after release");

    // R4 fault forces hold
    fault(8'h10, 32'hA000_0010);
    expect_obs(S_HOLD, 1, "R4 hold");
    expect_obs(S_IRQ, 1, "R12 irq");
    rd(A_STAT, 0, "R4 status +1");
    tick();
    rd(A_STAT, 0, "R4 status +2 cycle");
    tick();
    rd(A_STAT, 1, "R4 status held");
    rd(A_ISR, 32'h10, "R4 isr bit4");
    rd(A_RD, 32'hA000_0010, "R5 read-side addr");

    // R6 first address retained
    fault(8'h20, 32'hB000_0020);
    rd(A_RD, 32'hA000_0010, "R6 rd addr kept");
    rd(A_ISR, 32'h30, "R6 isr accum");

    // R6 simultaneous faults, R5 routing
    fault(8'h49, 32'hC000_0004);
    rd(A_ISR, 32'h79, "R6 all bits set");
    rd(A_PG, 32'hC000_0004, "R5 page addr");
    rd(A_BE, 32'hC000_0004, "R5 bus addr");
    rd(A_WR, 32'hC000_0004, "R5 write addr");

    // R8 resume ignored while pending
    wr(A_CTRL, 32'h5);
    expect_obs(S_HOLD, 1, "R8 hold kept");
    sync();
    wr(A_CTRL, 32'h0);
    expect_obs(S_ON, 1, "R8 off ignored");
    sync();

    // R7 partial clear
    wr(A_CLR, 32'h10);
    rd(A_ISR, 32'h69, "R7 partial clear");
    fault(8'h02, 32'hD000_0000);
    rd(A_ISR, 32'h6B, "R5 bit1 set");
    rd(A_RD, 32'hA000_0010, "R6 group still pending");

    // R7 clear and fault same cycle
    reg_addr = A_CLR; reg_wr = 1'b1; reg_wdata = 32'h02;
    flt_hit = 8'h02; flt_va = 32'hD000_1000;
    tick();
    reg_wr = 1'b0; flt_hit = '0;
    rd(A_ISR, 32'h6B, "R7 fault wins clear");

    // R12 clear all, then R8 resume
    wr(A_CLR, 32'hFF);
    expect_obs(S_IRQ, 0, "R12 irq low");
    expect_obs(S_HOLD, 1, "R8 hold until resume");
    rd(A_ISR, 0, "R7 all cleared");
    wr(A_CTRL, 32'h5);
    expect_obs(S_HOLD, 0, "R8 resumed");
    rd(A_STAT, 0, "R8 status cleared");

    // R6 recapture after clear
    fault(8'h04, 32'hE000_0008);
    rd(A_WR, 32'hE000_0008, "R6 recapture");
    wr(A_CLR, 32'h04);
    wr(A_CTRL, 32'h5);

    // R9 flush all
    wr(A_FLA, 32'h1);
    expect_obs(S_FA, 1, "R9 pulse");
    sync();
    tick();
    expect_obs(S_FA, 0, "R9 one cycle");
    sync();
    wr(A_FLA, 32'h0);
    expect_obs(S_FA, 0, "R9 bit0 clear no pulse");
    sync();

    // R10 flush one
    wr(A_FL1, 32'h1234_5001);
    expect_obs(S_FO, 1, "R10 pulse");
    expect_obs(S_FVA, 32'h12345, "R10 page");
    sync();
    tick();
    expect_obs(S_FO, 0, "R10 one cycle");
    sync();
    wr(A_FL1, 32'h1234_5000);
    expect_obs(S_FO, 0, "R10 bit0 clear no pulse");
    sync();

    // R2 disable
    wr(A_CTRL, 32'h0);
    expect_obs(S_ON, 0, "R2 off");
    expect_obs(S_HOLD, 0, "R2 off hold");
    rd(A_CTRL, 0, "R2 ctrl off");

    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule